// File: doc/BRIEF.md
# Looping Pattern Memory Transmitter

This block stores a test pattern in an on-chip word memory and replays it without end. Each clock, an address counter picks the next word. When the counter reaches the last location it wraps to zero, so the pattern repeats forever. Each word is split into byte lanes for a downstream serializer. Every lane carries a flag that tells whether the byte is data or an idle character. Line coding and serialization happen outside this block.

Two inputs control playback: `go` and `ctl_mode`. Data flows only while `go` is high and `ctl_mode` is low. If `ctl_mode` is high, the lanes carry the idle code, even when `go` is set. This lets the link be armed first and started later by clearing `ctl_mode`. A host port can load and read back the memory. It is served only while `go` is low; any host request made while `go` is high is refused with an error pulse.

The depth is 2**`ADDR_W` words. Setting `ADDR_W` = 14 gives 16K words. The word width is `LANES` x `LANE_W` bits, 32 by default.

Top module: `pattern_player`

## Requirements
- R1: After reset, every lane shows `IDLE_CODE` (default 8'hBC) with its control flag at 1, and `host_ack` and `host_err` are 0.
- R2: In any cycle where `go` is low or `ctl_mode` is high, the lanes show `IDLE_CODE` with every `lane_ctl` bit at 1, one clock later.
- R3: The block runs when `go` is high and `ctl_mode` is low. In the first running cycle, the outputs one clock later show memory word 0. Lane k carries word bits [8k+7:8k], and every `lane_ctl` bit is 0.
- R4: While running, each later clock presents the next memory word in address order, one word per clock.
- R5: After the last location (2**`ADDR_W`-1), playback wraps to location 0 and the pattern repeats.
- R6: Taking `go` low stops data: the lanes return to idle one clock later. The address is cleared, so the next run starts again at word 0.
- R7: With `go` low, a host write stores `host_wdata` at `host_addr`. A host read returns the stored word on `host_rdata` one clock later, together with a one-cycle `host_ack`.
- R8: A host request made while `go` is high is ignored and the memory is left unchanged. One clock later `host_err` is 1 and `host_ack` is 0.
- R9: Raising `ctl_mode` while `go` stays high pauses playback. The address holds, and when `ctl_mode` falls again playback resumes with the word after the last one sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Enable playback; clearing it resets the address |
| ctl_mode | input | 1 | 1 = send idle codes, 0 = send pattern data |
| host_req | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | LANES*LANE_W | Host write data |
| host_ack | output | 1 | Host access served (read data valid) |
| host_err | output | 1 | Host access refused because `go` was high |
| host_rdata | output | LANES*LANE_W | Host read data |
| lane_bytes | output | LANES*LANE_W | Lane bytes, lane k at bits [8k+7:8k] |
| lane_ctl | output | LANES | Per-lane flag, 1 = idle code |

## Verification
The bench fills a 16-word memory with a pattern that has a different byte in every lane, then checks playback across the wrap point. A lane-order bug or a wrong wrap would show the wrong byte or skip word 0. It also stops and restarts playback. A design that kept the address after `go` fell would resume mid-pattern instead of at word 0. A write attempted while armed must produce an error, and a later readback must return the old contents. A pause through `ctl_mode` must resume on the next word rather than repeat one or skip one.

// File: rtl/pattern_player.sv
module pattern_player #(
  parameter int ADDR_W = 10,
  parameter int LANES = 4,
  parameter int LANE_W = 8,
  parameter logic [LANE_W-1:0] IDLE_CODE = 8'hBC
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      go,
  input  logic                      ctl_mode,
  input  logic                      host_req,
  input  logic                      host_we,
  input  logic [ADDR_W-1:0]         host_addr,
  input  logic [LANES*LANE_W-1:0]   host_wdata,
  output logic                      host_ack,
  output logic                      host_err,
  output logic [LANES*LANE_W-1:0]   host_rdata,
  output logic [LANES*LANE_W-1:0]   lane_bytes,
  output logic [LANES-1:0]          lane_ctl
);
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_q;
  logic [ADDR_W-1:0] addr;
  logic run_q;

  wire running = go && !ctl_mode;
  wire host_ok = host_req && !go;
  wire [ADDR_W-1:0] rd_addr = go ? addr : host_addr;

  always_ff @(posedge clk) begin
    if (host_ok && host_we) mem[host_addr] <= host_wdata;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      run_q <= 1'b0;
      host_ack <= 1'b0;
      host_err <= 1'b0;
    end else begin
      if (!go) addr <= '0;
      else if (running) addr <= addr + 1'b1;
      run_q <= running;
      host_ack <= host_ok;
      host_err <= host_req && go;
    end
  end

  assign host_rdata = rd_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bytes[g*LANE_W +: LANE_W] = run_q ? rd_q[g*LANE_W +: LANE_W] : IDLE_CODE;
    assign lane_ctl[g] = ~run_q;
  end

  // R2
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!go || ctl_mode) |=> (&lane_ctl));

  // R3
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go) |-> (addr == '0));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (&addr)) |=> (addr == '0));

  // R6
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (addr == '0));

  // R8
  host_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && go) |=> (host_err && !host_ack));

  // R7
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_ack, host_err}));
endmodule

// File: tb/pattern_player_tb.sv
module pattern_player_tb;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] IDLE = 8'hBC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, ctl_mode = 1'b1;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic host_ack, host_err;
  logic [31:0] host_rdata, lane_bytes;
  logic [3:0] lane_ctl;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  pattern_player #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .ctl_mode(ctl_mode),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_err(host_err),
    .host_rdata(host_rdata), .lane_bytes(lane_bytes), .lane_ctl(lane_ctl));

  function automatic logic [31:0] pat(int i);
    logic [7:0] b = 8'(i);
    return {b ^ 8'h5A, b + 8'h11, ~b, b};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_idle(string req);
    check(req, {28'd0, lane_ctl, lane_bytes}, {28'd0, 4'hF, {4{IDLE}}});
  endtask

  task automatic check_word(string req, int i);
    check(req, {28'd0, lane_ctl, lane_bytes}, {28'd0, 4'h0, pat(i % DEPTH)});
  endtask

  task automatic host_write(int a, logic [31:0] d);
    host_req = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_read(string req, int a, logic [31:0] exp);
    host_req = 1'b1; host_we = 1'b0; host_addr = AW'(a);
    @(negedge clk);
    host_req = 1'b0;
    check(req, {31'd0, host_ack, host_rdata}, {31'd0, 1'b1, exp});
  endtask

  task automatic test_reset();
    rst_n = 1'b0; go = 1'b0; ctl_mode = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check_idle("R1");
    check("R1 ack/err", {host_ack, host_err}, 2'b00);
  endtask

  task automatic test_load();
    for (int i = 0; i < DEPTH; i++) host_write(i, pat(i));
    host_read("R7", 0, pat(0));
    host_read("R7", 5, pat(5));
    host_read("R7", DEPTH - 1, pat(DEPTH - 1));
  endtask

  task automatic test_run_wrap();
    go = 1'b1; ctl_mode = 1'b1;
    @(negedge clk);
    check_idle("R2 armed");
    ctl_mode = 1'b0;
    @(negedge clk);
    check_word("R3", 0);
    for (int i = 1; i < DEPTH + 3; i++) begin
      @(negedge clk);
      check_word(i < DEPTH ? "R4" : "R5", i);
    end
  endtask

  task automatic test_stop_restart();
    go = 1'b0; ctl_mode = 1'b1;
    @(negedge clk);
    check_idle("R6 stop");
    @(negedge clk);
    check_idle("R2 stopped");
    go = 1'b1; ctl_mode = 1'b0;
    @(negedge clk);
    check_word("R6 restart", 0);
    @(negedge clk);
    check_word("R6 next", 1);
  endtask

  task automatic test_pause();
    @(negedge clk);
    check_word("R9 pre", 2);
    ctl_mode = 1'b1;
    @(negedge clk);
    check_idle("R9 paused");
    @(negedge clk);
    check_idle("R9 paused");
    ctl_mode = 1'b0;
    @(negedge clk);
    check_word("R9 resume", 3);
  endtask

  task automatic test_blocked();
    ctl_mode = 1'b1;
    host_write(3, 32'hDEAD_BEEF);
    check("R8 write err", {host_ack, host_err}, 2'b01);
    host_req = 1'b1; host_we = 1'b0; host_addr = AW'(4);
    @(negedge clk);
    host_req = 1'b0;
    check("R8 read err", {host_ack, host_err}, 2'b01);
    go = 1'b0;
    @(negedge clk);
    check("R8 err clears", {host_ack, host_err}, 2'b00);
    host_read("R8 unchanged", 3, pat(3));
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    test_load();
    test_run_wrap();
    test_stop_restart();
    test_pause();
    test_blocked();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule